// File: doc/BRIEF.md
# Active-Rule Sequential Fuzzy Inference Engine

This block is the inference stage of a two-input fuzzy controller. Each input arrives from its fuzzifier as a pair of neighbouring active fuzzy sets, with a 3-bit set index and a 6-bit membership degree for each. Only the rules that combine active sets can fire. With two inputs and two overlapping sets per input, that makes four rules per evaluation. The engine evaluates just those four rules and does not scan the full rule base.

A 2-bit selector steps through the four combinations, one per clock. For each combination the engine forms a 6-bit rule address from the two chosen set indices and reads an 8-bit singleton consequent from a constant rule table. In the same cycle it computes the firing strength as the smaller of the two chosen degrees. The consequent, the strength, a valid flag and a last flag stream out serially to a downstream defuzzifier.

A start pulse that arrives while a sequence is running is held in a single pending slot. It is issued as soon as the current fourth rule leaves, so back-to-back evaluations have no idle cycle between them.

Top module: `fz_active_rule_engine`

## Requirements
- R1: After reset, and before any start, rule_valid_o and rule_last_o are 0 and cons_o and strength_o are 0.
- R2: Suppose start_i is sampled high at a rising edge while the engine is idle. Four rules then appear at the outputs on the next four rising edges, and rule_valid_o is high for exactly those four cycles.
- R3: Rule r (r = 0..3, in issue order) takes the second active set of input A when bit 1 of r is set, and the second active set of input B when bit 0 of r is set. Otherwise it takes the first set. The issue order is therefore 00, 01, 10, 11, where the first set is idx0/deg0 and the second is idx1/deg1.
- R4: The rule address is {selected A index, selected B index}, with A in bits 5:3 and B in bits 2:0. The consequent read at address {hi, lo} is (11 * (2*hi + lo)) mod 256.
- R5: strength_o is the minimum of the two selected 6-bit degrees. When the two degrees are equal, it is that common value.
- R6: rule_last_o is high only together with the fourth rule of a sequence.
- R7: While rule_valid_o is low, cons_o and strength_o are 0.
- R8: A start sampled while a sequence is in progress is held. Its first rule follows the current fourth rule on the very next cycle.
- R9: If several starts are sampled during one sequence, only the most recent one is issued. The earlier ones are discarded.
- R10: A start sampled at the edge that issues the fourth rule, with nothing pending, begins its own sequence on the following cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the operand set on this edge |
| a_idx0_i | input | 3 | Input A, first active set index |
| a_idx1_i | input | 3 | Input A, second active set index |
| a_deg0_i | input | 6 | Input A, degree in the first set |
| a_deg1_i | input | 6 | Input A, degree in the second set |
| b_idx0_i | input | 3 | Input B, first active set index |
| b_idx1_i | input | 3 | Input B, second active set index |
| b_deg0_i | input | 6 | Input B, degree in the first set |
| b_deg1_i | input | 6 | Input B, degree in the second set |
| cons_o | output | 8 | Rule consequent |
| strength_o | output | 6 | Rule firing strength |
| rule_valid_o | output | 1 | A rule is present on the outputs |
| rule_last_o | output | 1 | Fourth rule of the sequence |

## Verification
The bench sweeps all 64 index pairs with varied degrees, including equal degrees and the extremes 0 and 63. Several faults show up in this sweep:
- Swapped address halves give a wrong consequent, because the table weights the two halves differently.
- Swapped selector bits reorder rules 01 and 10.
- An inverted minimum picks the larger degree.

Three timing corners are targeted next:
- A start during a busy sequence: a design without the pending slot would drop that start.
- Two starts in one sequence: a design that keeps the first start instead of the newest would issue the stale operands.
- A start on the fourth-rule edge: a design that wastes a cycle there would insert a bubble, and the bench would see the valid flag drop.

// File: rtl/fz_inf_pkg.sv
package fz_inf_pkg;
  parameter int IDX_W  = 3;
  parameter int DEG_W  = 6;
  parameter int CONS_W = 8;
  parameter int SEL_W  = 2;
  localparam int ADDR_W = 2 * IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [IDX_W-1:0] idx0;
    logic [IDX_W-1:0] idx1;
    logic [DEG_W-1:0] deg0;
    logic [DEG_W-1:0] deg1;
  } fz_term_t;

  function automatic logic [CONS_W-1:0] rule_cons(input int unsigned hi,
                                                   input int unsigned lo,
                                                   input int unsigned mul);
    logic [31:0] t;
    t = mul * (2 * hi + lo);
    return t[CONS_W-1:0];
  endfunction
endpackage

// File: rtl/fz_rule_rom.sv
module fz_rule_rom
  import fz_inf_pkg::*;
#(
  parameter int unsigned MUL = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CONS_W-1:0] cons_o
);
  logic [CONS_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = rule_cons(g >> IDX_W, g % (1 << IDX_W), MUL);
  end

  assign cons_o = tbl[addr_i];
endmodule

// File: rtl/fz_min_sel.sv
module fz_min_sel
  import fz_inf_pkg::*;
(
  input  fz_term_t          term_a_i,
  input  fz_term_t          term_b_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DEG_W-1:0]  strength_o
);
  logic [IDX_W-1:0] ia, ib;
  logic [DEG_W-1:0] da, db;

  // sel_i[1] chooses input A's set, sel_i[0] chooses input B's set
  always_comb begin
    ia = sel_i[1] ? term_a_i.idx1 : term_a_i.idx0;
    da = sel_i[1] ? term_a_i.deg1 : term_a_i.deg0;
    ib = sel_i[0] ? term_b_i.idx1 : term_b_i.idx0;
    db = sel_i[0] ? term_b_i.deg1 : term_b_i.deg0;
  end

  assign addr_o     = {ia, ib};
  assign strength_o = (da < db) ? da : db;
endmodule

// File: rtl/fz_rule_seq.sv
module fz_rule_seq
  import fz_inf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  fz_term_t         term_a_i,
  input  fz_term_t         term_b_i,
  output logic             active_o,
  output logic [SEL_W-1:0] sel_o,
  output fz_term_t         cur_a_o,
  output fz_term_t         cur_b_o
);
  localparam logic [SEL_W-1:0] SEL_LAST = '1;

  logic             active_q, pend_v_q;
  logic [SEL_W-1:0] sel_q;
  fz_term_t         cur_a_q, cur_b_q, pend_a_q, pend_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_v_q <= 1'b0;
      sel_q    <= '0;
      cur_a_q  <= '0;
      cur_b_q  <= '0;
      pend_a_q <= '0;
      pend_b_q <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        sel_q    <= '0;
        cur_a_q  <= term_a_i;
        cur_b_q  <= term_b_i;
      end
    end else if (sel_q == SEL_LAST) begin
      if (pend_v_q) begin
        sel_q   <= '0;
        cur_a_q <= pend_a_q;
        cur_b_q <= pend_b_q;
        if (start_i) begin
          pend_a_q <= term_a_i;
          pend_b_q <= term_b_i;
        end else begin
          pend_v_q <= 1'b0;
        end
      end else if (start_i) begin
        sel_q   <= '0;
        cur_a_q <= term_a_i;
        cur_b_q <= term_b_i;
      end else begin
        active_q <= 1'b0;
      end
    end else begin
      sel_q <= sel_q + 1'b1;
      if (start_i) begin
        // newest start replaces any older pending one
        pend_v_q <= 1'b1;
        pend_a_q <= term_a_i;
        pend_b_q <= term_b_i;
      end
    end
  end

  assign active_o = active_q;
  assign sel_o    = sel_q;
  assign cur_a_o  = cur_a_q;
  assign cur_b_o  = cur_b_q;

  // R3
  sel_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && sel_q != SEL_LAST |=> active_q && sel_q == $past(sel_q) + 1'b1);

  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && sel_q != SEL_LAST && start_i |=> pend_v_q);

  // R10
  no_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && sel_q == SEL_LAST && start_i |=> active_q && sel_q == '0);
endmodule

// File: rtl/fz_active_rule_engine.sv
module fz_active_rule_engine
  import fz_inf_pkg::*;
#(
  parameter int unsigned CONS_MUL = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  a_idx0_i,
  input  logic [IDX_W-1:0]  a_idx1_i,
  input  logic [DEG_W-1:0]  a_deg0_i,
  input  logic [DEG_W-1:0]  a_deg1_i,
  input  logic [IDX_W-1:0]  b_idx0_i,
  input  logic [IDX_W-1:0]  b_idx1_i,
  input  logic [DEG_W-1:0]  b_deg0_i,
  input  logic [DEG_W-1:0]  b_deg1_i,
  output logic [CONS_W-1:0] cons_o,
  output logic [DEG_W-1:0]  strength_o,
  output logic              rule_valid_o,
  output logic              rule_last_o
);
  fz_term_t          in_a, in_b, cur_a, cur_b;
  logic              active;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] addr;
  logic [DEG_W-1:0]  str_d;
  logic [CONS_W-1:0] cons_d;

  assign in_a = '{idx0: a_idx0_i, idx1: a_idx1_i, deg0: a_deg0_i, deg1: a_deg1_i};
  assign in_b = '{idx0: b_idx0_i, idx1: b_idx1_i, deg0: b_deg0_i, deg1: b_deg1_i};

  fz_rule_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .term_a_i (in_a),
    .term_b_i (in_b),
    .active_o (active),
    .sel_o    (sel),
    .cur_a_o  (cur_a),
    .cur_b_o  (cur_b)
  );

  fz_min_sel u_sel (
    .term_a_i   (cur_a),
    .term_b_i   (cur_b),
    .sel_i      (sel),
    .addr_o     (addr),
    .strength_o (str_d)
  );

  fz_rule_rom #(.MUL(CONS_MUL)) u_rom (
    .addr_i (addr),
    .cons_o (cons_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_o       <= '0;
      strength_o   <= '0;
      rule_valid_o <= 1'b0;
      rule_last_o  <= 1'b0;
    end else begin
      cons_o       <= active ? cons_d : '0;
      strength_o   <= active ? str_d  : '0;
      rule_valid_o <= active;
      rule_last_o  <= active && (sel == '1);
    end
  end

  // R6
  last_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rule_last_o |-> rule_valid_o);

  // R2
  burst_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rule_valid_o && !rule_last_o |=> rule_valid_o);

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rule_valid_o |-> cons_o == '0 && strength_o == '0);
endmodule

// File: tb/fz_active_rule_engine_tb.sv
`timescale 1ns/1ps
module fz_active_rule_engine_tb;
  import fz_inf_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  fz_term_t ta = '0, tb = '0;
  logic [7:0] cons;
  logic [5:0] str;
  logic vld, last;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fz_active_rule_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_idx0_i(ta.idx0), .a_idx1_i(ta.idx1), .a_deg0_i(ta.deg0), .a_deg1_i(ta.deg1),
    .b_idx0_i(tb.idx0), .b_idx1_i(tb.idx1), .b_deg0_i(tb.deg0), .b_deg1_i(tb.deg1),
    .cons_o(cons), .strength_o(str), .rule_valid_o(vld), .rule_last_o(last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // rule r of operand pair (a,b) must be on the outputs now
  task automatic chk_rule(input fz_term_t a, input fz_term_t b, input int r);
    int ia, ib, da, db;
    ia = r[1] ? a.idx1 : a.idx0;
    da = r[1] ? a.deg1 : a.deg0;
    ib = r[0] ? b.idx1 : b.idx0;
    db = r[0] ? b.deg1 : b.deg0;
    chk("R2 valid", vld, 1);
    chk("R4 R3 cons", cons, (11 * (2 * ia + ib)) % 256);
    chk("R5 strength", str, (da < db) ? da : db);
    chk("R6 last", last, (r == 3) ? 1 : 0);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R7 valid"}, vld, 0);
    chk({tag, " R7 cons"}, cons, 0);
    chk({tag, " R7 strength"}, str, 0);
  endtask

  function automatic fz_term_t mk(input int i, input int d0, input int d1);
    fz_term_t t;
    t.idx0 = 3'(i);
    t.idx1 = 3'(i + 1);
    t.deg0 = 6'(d0);
    t.deg1 = 6'(d1);
    return t;
  endfunction

  task automatic run_one(input fz_term_t a, input fz_term_t b);
    ta = a; tb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      chk_rule(a, b, r);
    end
  endtask

  always @(posedge clk) begin
    if (!done && $time > 64'd1_500_000) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fz_term_t a0, b0, a1, b1, a2, b2;
    repeat (3) @(negedge clk);
    chk("R1 valid", vld, 0);
    chk("R1 last", last, 0);
    chk("R1 cons", cons, 0);
    chk("R1 strength", str, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 post");

    // sweep every index pair with varied degrees
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        int da, db;
        da = (ia * 9 + ib * 5) % 64;
        db = (ia * 7 + ib * 13 + 3) % 64;
        run_one(mk(ia, da, 63 - da), mk(ib, db, 63 - db));
      end
    end
    @(negedge clk);
    chk_idle("sweep end");

    // R5 ties and extremes
    run_one(mk(2, 17, 40), mk(5, 17, 40));
    run_one(mk(7, 0, 63), mk(0, 63, 0));
    run_one(mk(3, 63, 63), mk(4, 0, 0));
    @(negedge clk);

    // R8 R9: two starts during one sequence, only the newest survives
    a0 = mk(1, 10, 50); b0 = mk(6, 30, 20);
    a1 = mk(4, 5, 5);   b1 = mk(2, 60, 1);
    a2 = mk(5, 22, 33); b2 = mk(3, 44, 11);
    ta = a0; tb = b0; start = 1'b1;
    @(negedge clk);
    ta = a1; tb = b1;
    @(negedge clk);
    chk_rule(a0, b0, 0);
    ta = a2; tb = b2;
    @(negedge clk);
    chk_rule(a0, b0, 1);
    start = 1'b0;
    for (int r = 2; r < 4; r++) begin
      @(negedge clk);
      chk_rule(a0, b0, r);
    end
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      chk_rule(a2, b2, r);   // R9 newest pending
    end
    @(negedge clk);
    chk_idle("R8 after");
    @(negedge clk);

    // R10: start on the fourth-rule edge with nothing pending
    ta = a1; tb = b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); chk_rule(a1, b1, 0);
    @(negedge clk); chk_rule(a1, b1, 1);
    @(negedge clk); chk_rule(a1, b1, 2);
    ta = b2; tb = a0; start = 1'b1;
    @(negedge clk); chk_rule(a1, b1, 3);
    start = 1'b0;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      chk_rule(b2, a0, r);   // R10 no gap
    end
    @(negedge clk);
    chk_idle("R10 after");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule